// File: doc/BRIEF.md
# Grouped Interrupt Combiner

The combiner gathers a wide vector of level-sensitive interrupt lines into a much smaller set of group requests. Each group owns eight consecutive source lines. A source contributes to its group's request only while its line is high and software has enabled it. The group request is the OR of those contributions. In the default configuration there are 512 lines and 64 group outputs.

Software reaches the block through a simple synchronous word-addressed port. Each group of four adjacent groups, called a quad here, has four words. Two are write-only words that set or clear enable bits with write-one semantics. The other two are read-only status views: one shows the raw line state and one shows line state ANDed with enables. Two summary words after the last quad report the registered group outputs. A build-time option marks the instance as external-facing. In that mode, groups at or above a configured limit ignore their inputs.

Top module: `irq_comb_top`

## Requirements
- R1: Source line n belongs to group n>>3 at bit n&7, and group g occupies bits 8g+7..8g of any packed view.
- R2: The pending byte of each accepted group takes the level of its eight input lines at every clock edge. It is set while a line is high and clear while the line is low.
- R3: Output groupOut[g] is registered. At the first edge after an input or enable change, it becomes the OR-reduce of (enable & pending) for group g.
- R4: A write to word 0 of quad q (word address 4q) ORs byte k of the data into the enables of group 4q+k.
- R5: A write to word 1 of quad q (word address 4q+1) clears every enable of group 4q+k whose bit is 1 in byte k of the data. Enables whose bit is 0 are left unchanged.
- R6: A read of word 2 of quad q returns the raw pending bytes of groups 4q..4q+3 in byte lanes 0..3. A read of word 3 returns the same lanes ANDed with the enables.
- R7: Word addresses 64 and 65 (byte offsets 0x100 and 0x104) return groupOut[31:0] and groupOut[63:32].
- R8: A write to word 2 or 3 of a quad, to a summary word, or to an address past the summary words changes no state. Such a write raises err for exactly the one cycle after it.
- R9: rdData updates one cycle after rdEn and holds otherwise. Reads of enable words 0 and 1 and of addresses past the summary words return zero.
- R10: Reset clears all enables, pending bits, group outputs, rdData and err.
- R11: With EXT_MODE set, groups numbered EXT_GROUP_LIMIT and above ignore their inputs. Their raw status reads zero and their outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | 512 | Level-sensitive source lines |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 7 | Word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid one cycle after rdEn |
| err | output | 1 | One-cycle pulse after an illegal write |
| groupOut | output | 64 | Registered group requests |
| enFlat | output | 512 | Current enable bits, group g at bits 8g+7..8g |

## Verification
Every result of this block is due exactly one clock edge after its cause. A group output follows the edge that samples a changed input or applies an enable write. Read data follows the edge that captures rdEn. The error pulse follows the edge that captures an illegal write. The bench therefore drives all stimulus on the falling edge and checks on the next falling edge, one rising edge later. A status or summary read issued right after a write observes the state that write produced.

// File: rtl/irq_comb_pkg.sv
package irq_comb_pkg;

  // bits per group and groups per 32-bit register word
  localparam int GROUP_W = 8;
  localparam int GROUPS_PER_WORD = 32 / GROUP_W;
  // width of index fields carried in the control strobes
  localparam int CMB_IDX_W = 8;

  typedef enum logic [1:0] {
    RD_ZERO    = 2'd0,
    RD_RAW     = 2'd1,
    RD_MASKED  = 2'd2,
    RD_SUMMARY = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic                 setEn;
    logic                 clrEn;
    logic [CMB_IDX_W-1:0] quad;
    logic                 rdEn;
    rdSel_e               rdSel;
    logic [CMB_IDX_W-1:0] sumIdx;
  } ctrlCmd_t;

endpackage

// File: rtl/irq_comb_ctrl.sv
module irq_comb_ctrl
  import irq_comb_pkg::*;
#(
  parameter int NUM_GROUPS = 64,
  parameter int ADDR_W     = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output ctrlCmd_t          cmd,
  output logic              errR
);

  localparam int QUAD_WORDS = NUM_GROUPS;
  localparam int SUM_WORDS  = NUM_GROUPS / 32;
  localparam logic [ADDR_W-1:0] SUM_BASE_A = ADDR_W'(QUAD_WORDS);
  localparam logic [ADDR_W-1:0] SUM_LAST_A = ADDR_W'(QUAD_WORDS + SUM_WORDS - 1);

  logic inQuad, inSum, wrLegal;

  assign inQuad  = addr < SUM_BASE_A;
  assign inSum   = (addr >= SUM_BASE_A) && (addr <= SUM_LAST_A);
  assign wrLegal = inQuad && !addr[1];

  always_comb begin
    cmd        = '0;
    cmd.quad   = CMB_IDX_W'(addr[ADDR_W-1:2]);
    cmd.sumIdx = CMB_IDX_W'(addr - SUM_BASE_A);
    cmd.setEn  = wrEn && inQuad && (addr[1:0] == 2'd0);
    cmd.clrEn  = wrEn && inQuad && (addr[1:0] == 2'd1);
    cmd.rdEn   = rdEn;
    if (inQuad && addr[1:0] == 2'd2)      cmd.rdSel = RD_RAW;
    else if (inQuad && addr[1:0] == 2'd3) cmd.rdSel = RD_MASKED;
    else if (inSum)                       cmd.rdSel = RD_SUMMARY;
    else                                  cmd.rdSel = RD_ZERO;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errR <= 1'b0;
    else       errR <= wrEn && !wrLegal;
  end

endmodule

// File: rtl/irq_comb_dp.sv
module irq_comb_dp
  import irq_comb_pkg::*;
#(
  parameter int NUM_GROUPS      = 64,
  parameter int EXT_MODE        = 0,
  parameter int EXT_GROUP_LIMIT = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_GROUPS*GROUP_W-1:0] irqIn,
  input  ctrlCmd_t                      cmd,
  input  logic [31:0]                   wrData,
  output logic [31:0]                   rdData,
  output logic [NUM_GROUPS-1:0]         groupOut,
  output logic [NUM_GROUPS*GROUP_W-1:0] enFlat
);

  localparam int QUADS     = NUM_GROUPS / GROUPS_PER_WORD;
  localparam int QW        = $clog2(QUADS);
  localparam int SUM_WORDS = NUM_GROUPS / 32;
  localparam int SW        = (SUM_WORDS > 1) ? $clog2(SUM_WORDS) : 1;

  logic [NUM_GROUPS*GROUP_W-1:0] pendFlat;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int Q = g / GROUPS_PER_WORD;
    localparam int L = g % GROUPS_PER_WORD;
    logic [GROUP_W-1:0] enR, pendR, enNext, pendNext;
    logic               outR, quadHit;

    assign quadHit = (cmd.quad == CMB_IDX_W'(Q));

    always_comb begin
      enNext = enR;
      if (cmd.setEn && quadHit)      enNext = enR | wrData[L*GROUP_W +: GROUP_W];
      else if (cmd.clrEn && quadHit) enNext = enR & ~wrData[L*GROUP_W +: GROUP_W];
    end

    if (EXT_MODE != 0 && g >= EXT_GROUP_LIMIT) begin : g_ign
      assign pendNext = pendR;
    end else begin : g_live
      assign pendNext = irqIn[g*GROUP_W +: GROUP_W];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enR   <= '0;
        pendR <= '0;
        outR  <= 1'b0;
      end else begin
        enR   <= enNext;
        pendR <= pendNext;
        outR  <= |(enNext & pendNext);
      end
    end

    assign enFlat[g*GROUP_W +: GROUP_W]   = enR;
    assign pendFlat[g*GROUP_W +: GROUP_W] = pendR;
    assign groupOut[g]                    = outR;
  end

  logic [31:0] rawW [QUADS];
  logic [31:0] mskW [QUADS];
  logic [31:0] sumW [SUM_WORDS];

  for (genvar q = 0; q < QUADS; q++) begin : g_word
    assign rawW[q] = pendFlat[q*32 +: 32];
    assign mskW[q] = pendFlat[q*32 +: 32] & enFlat[q*32 +: 32];
  end

  for (genvar s = 0; s < SUM_WORDS; s++) begin : g_sum
    assign sumW[s] = groupOut[s*32 +: 32];
  end

  logic [31:0] rdNext;

  always_comb begin
    case (cmd.rdSel)
      RD_RAW:     rdNext = rawW[cmd.quad[QW-1:0]];
      RD_MASKED:  rdNext = mskW[cmd.quad[QW-1:0]];
      RD_SUMMARY: rdNext = sumW[cmd.sumIdx[SW-1:0]];
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         rdData <= '0;
    else if (cmd.rdEn) rdData <= rdNext;
  end

endmodule

// File: rtl/irq_comb_top.sv
module irq_comb_top
  import irq_comb_pkg::*;
#(
  parameter int NUM_GROUPS      = 64,
  parameter int EXT_MODE        = 0,
  parameter int EXT_GROUP_LIMIT = 16,
  localparam int ADDR_W         = $clog2(NUM_GROUPS + NUM_GROUPS / 32),
  localparam int SRC_W          = NUM_GROUPS * GROUP_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [SRC_W-1:0]      irqIn,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [31:0]           wrData,
  output logic [31:0]           rdData,
  output logic                  err,
  output logic [NUM_GROUPS-1:0] groupOut,
  output logic [SRC_W-1:0]      enFlat
);

  ctrlCmd_t cmd;

  irq_comb_ctrl #(
    .NUM_GROUPS(NUM_GROUPS),
    .ADDR_W    (ADDR_W)
  ) u_ctrl (
    .clk (clk),
    .rstN(rstN),
    .wrEn(wrEn),
    .rdEn(rdEn),
    .addr(addr),
    .cmd (cmd),
    .errR(err)
  );

  irq_comb_dp #(
    .NUM_GROUPS     (NUM_GROUPS),
    .EXT_MODE       (EXT_MODE),
    .EXT_GROUP_LIMIT(EXT_GROUP_LIMIT)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .irqIn   (irqIn),
    .cmd     (cmd),
    .wrData  (wrData),
    .rdData  (rdData),
    .groupOut(groupOut),
    .enFlat  (enFlat)
  );

endmodule

// File: rtl/irq_comb_chk.sv
module irq_comb_chk #(
  parameter int NUM_GROUPS      = 64,
  parameter int EXT_MODE        = 0,
  parameter int EXT_GROUP_LIMIT = 16,
  parameter int ADDR_W          = 7
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [NUM_GROUPS*8-1:0] irqIn,
  input logic                    wrEn,
  input logic                    rdEn,
  input logic [ADDR_W-1:0]       addr,
  input logic [31:0]             wrData,
  input logic [31:0]             rdData,
  input logic                    err,
  input logic [NUM_GROUPS-1:0]   groupOut,
  input logic [NUM_GROUPS*8-1:0] enFlat
);

  localparam int QUADS = NUM_GROUPS / 4;
  localparam int QW    = $clog2(QUADS);
  localparam logic [ADDR_W-1:0] SUM_BASE_A = ADDR_W'(NUM_GROUPS);

  logic inQuad, setAddr, clrAddr, badWrite;
  assign inQuad   = addr < SUM_BASE_A;
  assign setAddr  = inQuad && (addr[1:0] == 2'd0);
  assign clrAddr  = inQuad && (addr[1:0] == 2'd1);
  assign badWrite = wrEn && !(inQuad && !addr[1]);

  logic [QW-1:0] lastQuad;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastQuad <= '0;
    else       lastQuad <= addr[QW+1:2];
  end

  logic [31:0] enW [QUADS];
  for (genvar q = 0; q < QUADS; q++) begin : g_w
    assign enW[q] = enFlat[q*32 +: 32];
  end
  logic [31:0] enWordLast;
  assign enWordLast = enW[lastQuad];

  p_set_sticks_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && setAddr) |=> ((enWordLast & $past(wrData)) == $past(wrData)));

  p_clr_drops_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && clrAddr) |=> ((enWordLast & $past(wrData)) == 32'd0));

  p_bad_write_keeps_en_r8: assert property (@(posedge clk) disable iff (!rstN)
    badWrite |=> $stable(enFlat));

  p_err_after_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    err |-> $past(badWrite));

  p_idle_lines_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    (irqIn == '0) |=> (groupOut == '0));

  p_summary_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == SUM_BASE_A) |=> (rdData == $past(groupOut[31:0])));

  if (EXT_MODE != 0) begin : g_ext
    p_ext_ignored_r11: assert property (@(posedge clk) disable iff (!rstN)
      ((groupOut >> EXT_GROUP_LIMIT) == '0));
  end

endmodule

bind irq_comb_top irq_comb_chk #(
  .NUM_GROUPS     (NUM_GROUPS),
  .EXT_MODE       (EXT_MODE),
  .EXT_GROUP_LIMIT(EXT_GROUP_LIMIT),
  .ADDR_W         (ADDR_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .irqIn   (irqIn),
  .wrEn    (wrEn),
  .rdEn    (rdEn),
  .addr    (addr),
  .wrData  (wrData),
  .rdData  (rdData),
  .err     (err),
  .groupOut(groupOut),
  .enFlat  (enFlat)
);

// File: tb/irq_comb_top_tb.sv
module irq_comb_top_tb;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [511:0] irqIn = '0;
  logic         wrEn = 1'b0;
  logic         rdEn = 1'b0;
  logic [6:0]   addr = '0;
  logic [31:0]  wrData = '0;
  logic [31:0]  rdData, extRd;
  logic         err, extErr;
  logic [63:0]  groupOut, extOut;
  logic [511:0] enFlat, extEn;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  irq_comb_top u_dut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .err(err),
    .groupOut(groupOut), .enFlat(enFlat)
  );

  irq_comb_top #(.EXT_MODE(1), .EXT_GROUP_LIMIT(8)) u_ext (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(extRd), .err(extErr),
    .groupOut(extOut), .enFlat(extEn)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [6:0] a);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  // {isRead, wordAddr, data, expected}; for writes expected[0] is the err pulse
  localparam int NV = 27;
  localparam logic [71:0] VEC [NV] = '{
    {1'b1, 7'd2,  32'h0,        32'h0000000F},
    {1'b1, 7'd3,  32'h0,        32'h0},
    {1'b1, 7'd64, 32'h0,        32'h0},
    {1'b0, 7'd0,  32'h00000003, 32'h0},
    {1'b1, 7'd3,  32'h0,        32'h00000003},
    {1'b1, 7'd64, 32'h0,        32'h00000001},
    {1'b1, 7'd6,  32'h0,        32'h00008000},
    {1'b0, 7'd4,  32'h0000FF00, 32'h0},
    {1'b1, 7'd7,  32'h0,        32'h00008000},
    {1'b1, 7'd64, 32'h0,        32'h00000021},
    {1'b0, 7'd1,  32'h00000001, 32'h0},
    {1'b1, 7'd3,  32'h0,        32'h00000002},
    {1'b0, 7'd32, 32'h00000100, 32'h0},
    {1'b1, 7'd65, 32'h0,        32'h00000002},
    {1'b0, 7'd2,  32'hFFFFFFFF, 32'h1},
    {1'b1, 7'd3,  32'h0,        32'h00000002},
    {1'b0, 7'd64, 32'hFFFFFFFF, 32'h1},
    {1'b0, 7'd70, 32'hFFFFFFFF, 32'h1},
    {1'b1, 7'd64, 32'h0,        32'h00000021},
    {1'b0, 7'd60, 32'h80000000, 32'h0},
    {1'b1, 7'd62, 32'h0,        32'hFF000000},
    {1'b1, 7'd65, 32'h0,        32'h80000002},
    {1'b1, 7'd66, 32'h0,        32'h0},
    {1'b1, 7'd0,  32'h0,        32'h0},
    {1'b1, 7'd1,  32'h0,        32'h0},
    {1'b0, 7'd1,  32'h000000FF, 32'h0},
    {1'b1, 7'd64, 32'h0,        32'h00000020}
  };

  function automatic string tagFor(input logic isRd, input logic [6:0] a, input logic [31:0] e);
    if (!isRd) return (e[0]) ? "R8 illegal write err" : "R4/R5 enable write err";
    if (a >= 7'd66 || (a < 7'd64 && a[1] == 1'b0)) return "R9 zero read";
    if (a >= 7'd64) return "R7 summary read";
    return "R6/R1 status read";
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 groupOut after reset", groupOut, 64'h0);
    chk("R10 rdData after reset", {32'h0, rdData}, 64'h0);
    chk("R10 err after reset", {63'h0, err}, 64'h0);
    chk("R10 enables after reset", {63'h0, |enFlat}, 64'h0);
    rstN = 1'b1;

    // R1/R2: drive lines; group0 low nibble, group5 bit7, group33 bit0, group63 all
    @(negedge clk);
    irqIn[3:0]     = 4'hF;
    irqIn[5*8+7]   = 1'b1;
    irqIn[33*8]    = 1'b1;
    irqIn[511:504] = 8'hFF;
    @(negedge clk);
    chk("R3 no output without enables", groupOut, 64'h0);

    for (int i = 0; i < NV; i++) begin
      logic        isRd;
      logic [6:0]  a;
      logic [31:0] d, e;
      {isRd, a, d, e} = VEC[i];
      if (isRd) begin
        doRead(a);
        chk(tagFor(isRd, a, e), {32'h0, rdData}, {32'h0, e});
      end else begin
        doWrite(a, d);
        chk(tagFor(isRd, a, e), {63'h0, err}, {63'h0, e[0]});
        @(negedge clk);
        chk("R8 err lasts one cycle", {63'h0, err}, 64'h0);
      end
    end

    // R3: outputs now groups 5, 33, 63
    chk("R3 group outputs", groupOut, 64'h8000_0002_0000_0020);

    // R11: external instance ignores groups 8 and up
    chk("R11 ext outputs", extOut, 64'h0000_0000_0000_0020);
    doRead(7'd34);
    chk("R1 raw quad8 group33 lane1", {32'h0, rdData}, 64'h0000_0100);
    chk("R11 ext raw quad8 ignored", {32'h0, extRd}, 64'h0);

    // R2/R3: dropping a line clears pending and output at the next edge
    @(negedge clk);
    irqIn[5*8+7] = 1'b0;
    @(negedge clk);
    chk("R3 group5 falls one edge after line", {63'h0, groupOut[5]}, 64'h0);
    doRead(7'd6);
    chk("R2 raw quad1 after line low", {32'h0, rdData}, 64'h0);

    // R10: reset mid-run clears enables while lines stay high
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk("R10 outputs cleared by reset", groupOut, 64'h0);
    rstN = 1'b1;
    doRead(7'd63);
    chk("R10 masked quad15 after reset", {32'h0, rdData}, 64'h0);
    doRead(7'd62);
    chk("R2 raw quad15 reloads after reset", {32'h0, rdData}, 64'hFF00_0000);
    chk("R10 groupOut stays low without enables", groupOut, 64'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule